// File: doc/BRIEF.md
# Multiphase Oversampling Time Tagger

This block timestamps rising edges on four input channels with a nominal resolution of 1 ns. Four sampling clocks, all at 125 MHz and spaced 45 degrees apart, capture every input on both their rising and their falling edges. That gives eight samples per 8 ns coarse period. Each channel's eight samples pass through a ladder of registers that moves them, one phase edge at a time, into the 0-degree core clock domain. There they are checked for a low-to-high transition, and the position of the first transition is encoded as a 3-bit fine code.

A 48-bit coarse counter in the core domain never stops. In any coarse period where at least one channel saw an edge, the four channel fields and the coarse count of the sampling period are packed into a 64-bit tag word. The word is presented for one cycle together with a valid strobe. A downstream collector subtracts tags to obtain time differences between channels, with no dead time between periods.

Top module: `mp_time_tagger`

## Requirements
- R1: While `rstN` is low, `tagValid` is 0 and `tagWord` is all zeros.
- R2: Sample index i (0 to 7) of a coarse period is taken i ns after the core clock's rising edge. Index i in 0 to 3 uses the rising edge of `phaseClk[i]`, and index i in 4 to 7 uses the falling edge of `phaseClk[i-4]`. For a channel, the fine code is the lowest index whose sample is 1 while the sample one step earlier in time is 0. Such a period sets that channel's event bit.
- R3: The sample one step before index 0 is index 7 of the previous coarse period. A level that stays high across the boundary is not an event. A channel that was low at index 7 and is high at index 0 gives fine code 0.
- R4: At most one event per channel is recorded in a coarse period. When several rising edges fall in one period, only the earliest is reported.
- R5: `tagValid` is 1 for exactly one cycle for each coarse period in which at least one channel has an event. In every other cycle it is 0.
- R6: In the tag word, channel k occupies bits [51+4k:48+4k]. Bit 3 of the field is the event flag and bits 2:0 are the fine code. A channel without an event in that period reports 4'b0000.
- R7: Bits [47:0] carry a free-running coarse counter. The counter is 0 in reset and increases by one at every core clock edge after reset is released. The tag for the period that begins at core edge n appears after core edge n+2 and carries the counter value that held during that period, which is the current count minus 2.
- R8: Events on several channels in the same coarse period are reported together in one tag word, each channel with its own fine code.
- R9: A falling edge (1 to 0), or a level held low or held high, produces no event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkCore | input | 1 | 125 MHz core clock at 0 degrees; runs the coarse counter and the output |
| rstN | input | 1 | Asynchronous active-low reset |
| phaseClk | input | 4 | Sampling clocks at 0, 45, 90 and 135 degrees, bit k at k*45 degrees |
| chIn | input | 4 | Channel inputs whose rising edges are timestamped |
| tagValid | output | 1 | One-cycle strobe marking a new tag word |
| tagWord | output | 64 | Four 4-bit channel fields above the 48-bit coarse count |

## Verification
In a single cycle the decoder can have to combine a transition carried over from the previous period's last sample with several further edges inside the current period. That same cycle can also be the one where other channels report their own events into the shared word. The bench provokes this with back-to-back periods whose patterns end high, restart high or low, and contain repeated edges. It also runs long stretches of pseudo-random patterns on all four channels at once. A behavioural model computes each expected word from the stored sample patterns and the previous period's last bit, and it compares valid, every field and the coarse count on every core cycle.

// File: rtl/tt_pkg.sv
`timescale 1ns/100ps
package tt_pkg;
  parameter int TT_NUM_CH   = 4;
  parameter int TT_PHASES   = 4;
  parameter int TT_COARSE_W = 48;

  localparam int TT_SAMPLES = 2 * TT_PHASES;
  localparam int TT_FINE_W  = $clog2(TT_SAMPLES);
  localparam int TT_FIELD_W = TT_FINE_W + 1;
  localparam int TT_TAG_W   = TT_NUM_CH * TT_FIELD_W + TT_COARSE_W;

  // strobes from the control sequencer to the datapath
  typedef struct packed {
    logic                   capture;  // load retimed samples into the core domain
    logic                   emit;     // decoded result may be published
    logic [TT_COARSE_W-1:0] coarse;   // free-running coarse count
  } ctl_t;
endpackage

// File: rtl/tt_phase_ladder.sv
`timescale 1ns/100ps
// One channel: sample on every phase edge and walk the bits forward edge by edge
module tt_phase_ladder #(
  parameter int PHASES = tt_pkg::TT_PHASES
) (
  input  logic                  rstN,
  input  logic [PHASES-1:0]     phaseClk,
  input  logic                  din,
  output logic [2*PHASES-1:0]   samples
);
  localparam int S = 2 * PHASES;

  for (genvar e = 0; e < S; e++) begin : g_stg
    localparam logic [S-1:0] KEEP = S'((1 << e) - 1);
    logic [S-1:0] stage;
    logic [S-1:0] nxt;

    if (e == 0) begin : g_first
      assign nxt = S'(din);
    end else begin : g_next
      assign nxt = (g_stg[e-1].stage & KEEP) | (S'(din) << e);
    end

    if (e < PHASES) begin : g_rise
      always_ff @(posedge phaseClk[e] or negedge rstN) begin
        if (!rstN) stage <= '0;
        else       stage <= nxt;
      end
    end else begin : g_fall
      always_ff @(negedge phaseClk[e-PHASES] or negedge rstN) begin
        if (!rstN) stage <= '0;
        else       stage <= nxt;
      end
    end
  end

  assign samples = g_stg[S-1].stage;
endmodule

// File: rtl/tt_fine_decode.sv
`timescale 1ns/100ps
// Earliest low-to-high step in a sample vector, seeded by the previous period's last bit
module tt_fine_decode #(
  parameter int S  = tt_pkg::TT_SAMPLES,
  parameter int FW = tt_pkg::TT_FINE_W
) (
  input  logic [S-1:0]  vec,
  input  logic          prevLast,
  output logic          evt,
  output logic [FW-1:0] fine
);
  logic [S-1:0] rise;

  always_comb begin
    rise = vec & ~{vec[S-2:0], prevLast};
    evt  = |rise;
    fine = '0;
    for (int i = S - 1; i >= 0; i--) begin
      if (rise[i]) fine = FW'(i);
    end
  end
endmodule

// File: rtl/tt_control.sv
`timescale 1ns/100ps
// Coarse counter and pipeline-fill sequencing after reset
module tt_control (
  input  logic          clk,
  input  logic          rstN,
  output tt_pkg::ctl_t  ctl
);
  localparam int CW = tt_pkg::TT_COARSE_W;

  logic          armed;
  logic          armedD;
  logic [CW-1:0] coarseCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed     <= 1'b0;
      armedD    <= 1'b0;
      coarseCnt <= '0;
    end else begin
      armed     <= 1'b1;
      armedD    <= armed;
      coarseCnt <= coarseCnt + CW'(1);
    end
  end

  always_comb begin
    ctl.capture = armed;
    ctl.emit    = armedD;
    ctl.coarse  = coarseCnt;
  end
endmodule

// File: rtl/tt_datapath.sv
`timescale 1ns/100ps
// Core-domain capture, per-channel decode and tag packing
module tt_datapath (
  input  logic                                                clk,
  input  logic                                                rstN,
  input  tt_pkg::ctl_t                                        ctl,
  input  logic [tt_pkg::TT_NUM_CH-1:0][tt_pkg::TT_SAMPLES-1:0] ladderVec,
  output logic                                                tagValid,
  output logic [tt_pkg::TT_TAG_W-1:0]                         tagWord
);
  localparam int NCH = tt_pkg::TT_NUM_CH;
  localparam int S   = tt_pkg::TT_SAMPLES;
  localparam int FW  = tt_pkg::TT_FINE_W;
  localparam int CW  = tt_pkg::TT_COARSE_W;
  localparam int TW  = tt_pkg::TT_TAG_W;

  logic [NCH-1:0][S-1:0]             capVec;
  logic [NCH-1:0]                    prevBit;
  logic [CW-1:0]                     capCoarse;
  logic [NCH-1:0]                    evt;
  logic [NCH-1:0][tt_pkg::TT_FIELD_W-1:0] field;
  logic                              anyEvt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capVec    <= '0;
      prevBit   <= '0;
      capCoarse <= '0;
    end else if (ctl.capture) begin
      capVec    <= ladderVec;
      capCoarse <= ctl.coarse;
      for (int k = 0; k < NCH; k++) prevBit[k] <= capVec[k][S-1];
    end
  end

  for (genvar k = 0; k < NCH; k++) begin : g_dec
    logic [FW-1:0] fine;
    tt_fine_decode #(.S(S), .FW(FW)) u_dec (
      .vec      (capVec[k]),
      .prevLast (prevBit[k]),
      .evt      (evt[k]),
      .fine     (fine)
    );
    assign field[k] = {evt[k], fine};
  end

  assign anyEvt = |evt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tagValid <= 1'b0;
      tagWord  <= '0;
    end else begin
      tagValid <= ctl.emit && anyEvt;
      if (ctl.emit && anyEvt) tagWord <= TW'({field, capCoarse});
    end
  end
endmodule

// File: rtl/mp_time_tagger.sv
`timescale 1ns/100ps
module mp_time_tagger (
  input  logic        clkCore,
  input  logic        rstN,
  input  logic [3:0]  phaseClk,
  input  logic [3:0]  chIn,
  output logic        tagValid,
  output logic [63:0] tagWord
);
  localparam int NCH = tt_pkg::TT_NUM_CH;
  localparam int S   = tt_pkg::TT_SAMPLES;

  tt_pkg::ctl_t          ctl;
  logic [NCH-1:0][S-1:0] ladderVec;

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    tt_phase_ladder #(.PHASES(tt_pkg::TT_PHASES)) u_ladder (
      .rstN     (rstN),
      .phaseClk (phaseClk),
      .din      (chIn[k]),
      .samples  (ladderVec[k])
    );
  end

  tt_control u_ctl (
    .clk  (clkCore),
    .rstN (rstN),
    .ctl  (ctl)
  );

  tt_datapath u_dp (
    .clk       (clkCore),
    .rstN      (rstN),
    .ctl       (ctl),
    .ladderVec (ladderVec),
    .tagValid  (tagValid),
    .tagWord   (tagWord)
  );
endmodule

// File: rtl/mp_time_tagger_sva.sv
`timescale 1ns/100ps
module mp_time_tagger_sva (
  input logic         clkCore,
  input logic         rstN,
  input logic         tagValid,
  input logic [63:0]  tagWord,
  input tt_pkg::ctl_t ctl
);
  localparam int CW = tt_pkg::TT_COARSE_W;

  logic [3:0] evtBits;
  logic       idleOk;

  always_comb begin
    idleOk = 1'b1;
    for (int k = 0; k < 4; k++) begin
      evtBits[k] = tagWord[51 + 4*k];
      if (!evtBits[k] && (tagWord[50 + 4*k -: 3] != 3'd0)) idleOk = 1'b0;
    end
  end

  always @(posedge clkCore) begin
    if (!rstN) AST_RESET_QUIET: assert (!tagValid && tagWord == 64'd0); // R1
  end

  AST_COARSE_STEP: assert property (@(posedge clkCore) disable iff (!rstN)
    $past(rstN) |-> ctl.coarse == $past(ctl.coarse) + CW'(1)); // R7

  AST_TAG_COARSE_LAG: assert property (@(posedge clkCore) disable iff (!rstN)
    tagValid |-> tagWord[47:0] == ctl.coarse - CW'(2)); // R7

  AST_VALID_NEEDS_EVENT: assert property (@(posedge clkCore) disable iff (!rstN)
    tagValid |-> evtBits != 4'd0); // R5

  AST_IDLE_FIELD_ZERO: assert property (@(posedge clkCore) disable iff (!rstN)
    tagValid |-> idleOk); // R6
endmodule

bind mp_time_tagger mp_time_tagger_sva u_sva (
  .clkCore  (clkCore),
  .rstN     (rstN),
  .tagValid (tagValid),
  .tagWord  (tagWord),
  .ctl      (ctl)
);

// File: tb/mp_time_tagger_tb.sv
`timescale 1ns/100ps
module mp_time_tagger_tb;
  localparam int NW    = 200;  // coarse periods with stored patterns
  localparam int RELW  = 5;    // reset released 2 ns after core edge RELW
  localparam int LASTC = 180;

  logic        clkCore = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  phaseClk = '0;
  logic [3:0]  chIn = '0;
  logic        tagValid;
  logic [63:0] tagWord;

  logic [7:0] patMem [NW][4];
  string      reqTag [NW];
  int         total = 0;
  int         bad = 0;

  mp_time_tagger u_dut (
    .clkCore  (clkCore),
    .rstN     (rstN),
    .phaseClk (phaseClk),
    .chIn     (chIn),
    .tagValid (tagValid),
    .tagWord  (tagWord)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // expected 4-bit field of one channel for period w (R2, R3, R4, R9)
  function automatic logic [3:0] expField(input int w, input int ch);
    logic [7:0] cur;
    logic       prv;
    cur = patMem[w][ch];
    prv = (w > 0) ? patMem[w-1][ch][7] : 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (cur[i] && !((i == 0) ? prv : cur[i-1])) return {1'b1, 3'(i)};
    end
    return 4'b0000;
  endfunction

  // eight evenly spaced phase edges per 8 ns
  initial begin
    forever begin
      clkCore = 1'b1; phaseClk[0] = 1'b1; #1;
      phaseClk[1] = 1'b1; #1;
      phaseClk[2] = 1'b1; #1;
      phaseClk[3] = 1'b1; #1;
      clkCore = 1'b0; phaseClk[0] = 1'b0; #1;
      phaseClk[1] = 1'b0; #1;
      phaseClk[2] = 1'b0; #1;
      phaseClk[3] = 1'b0; #1;
    end
  end

  initial begin
    #(RELW * 8 + 2);
    rstN = 1'b1;
  end

  // sample i of period w is taken at 8w+i; drive it half a ns earlier
  initial begin
    #7.5;
    for (int w = 1; w < NW; w++) begin
      for (int i = 0; i < 8; i++) begin
        for (int ch = 0; ch < 4; ch++) chIn[ch] = patMem[w][ch][i];
        #1;
      end
    end
  end

  initial begin
    #(200000 * 8);
    total++;
    bad++;
    $display("FAIL R5 watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    for (int w = 0; w < NW; w++) begin
      reqTag[w] = "R5";
      for (int ch = 0; ch < 4; ch++) patMem[w][ch] = 8'h00;
    end
    patMem[10][0] = 8'hFF; reqTag[10] = "R2";
    patMem[11][0] = 8'hFF; reqTag[11] = "R9";   // held high
    reqTag[12] = "R9";                          // falling edge
    for (int i = 0; i < 8; i++) begin
      patMem[20 + 2*i][0] = 8'hFF << i; reqTag[20 + 2*i] = "R2";
      reqTag[21 + 2*i] = "R9";
    end
    patMem[40][1] = 8'h80; reqTag[40] = "R3";
    patMem[41][1] = 8'h01; reqTag[41] = "R3";   // high across boundary
    patMem[42][1] = 8'h01; reqTag[42] = "R3";   // new edge at index 0
    patMem[45][2] = 8'h26; reqTag[45] = "R4";
    patMem[46][2] = 8'h55; reqTag[46] = "R4";
    patMem[50][0] = 8'hF8; patMem[50][1] = 8'hC0;
    patMem[50][2] = 8'hFE; patMem[50][3] = 8'h80; reqTag[50] = "R8";
    seed = 32'h1234_5678;
    for (int w = 60; w < 160; w++) begin
      reqTag[w] = "R6";
      for (int ch = 0; ch < 4; ch++) begin
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        patMem[w][ch] = seed[7:0];
      end
    end

    for (int c = 0; c <= LASTC; c++) begin
      @(negedge clkCore);  // after core edge c
      if (c <= RELW) begin
        check(!tagValid && tagWord == 64'd0, "R1 reset quiet", {63'd0, tagValid} | tagWord, 64'd0);
      end else begin
        int         w;
        logic [15:0] expF;
        logic        expV;
        w    = c - 2;
        expF = '0;
        for (int ch = 0; ch < 4; ch++) expF[4*ch +: 4] = expField(w, ch);
        expV = (expF[3] | expF[7] | expF[11] | expF[15]);
        check(tagValid == expV, {reqTag[w], " valid"}, 64'(tagValid), 64'(expV));
        if (expV && tagValid) begin
          check(tagWord[63:48] == expF, {reqTag[w], " R6 fields"}, 64'(tagWord[63:48]), 64'(expF));
          check(tagWord[47:0] == 48'(w - RELW), "R7 coarse", 64'(tagWord[47:0]), 64'(w - RELW));
        end
      end
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule